// File: doc/BRIEF.md
# Single-Transfer DMA Bus Master

This block moves one data word between an internal FIFO and system memory by briefly taking over a shared system bus. When the FIFO raises a transfer request, the block captures the direction, address, write data and wait-state setting. It then raises a bus request and waits for the host to grant the bus. Once granted, it drives a single read or write access and holds it until two things are true: a programmed minimum number of wait states has elapsed, and memory reports ready. It then drops the bus straight away, so every bus tenure carries exactly one access.

If memory signals a bus error or an address error during the access, the block stops the access cleanly. It removes the strobes, gives up the bus and withholds the FIFO acknowledge. It also records a sticky system-fault flag that shows which error occurred. Until software clears that flag, the block accepts no further FIFO requests.

Top module: `dma_single_master`

## Requirements
- R1: While reset is held, and after reset is released, bus_req, addr_strobe, data_strobe, fifo_ack and fault_flag are all 0, and fault_kind is 2'b00.
- R2: A fifo_req seen with no fault pending raises bus_req on the next cycle. bus_req then stays high, with both strobes low, for as long as bus_grant is low.
- R3: Strobes begin only in the cycle after bus_grant is seen high. In the cycle after an access completes or aborts, bus_req and both strobes are low, so each grant serves exactly one access.
- R4: With wait_cfg = W, and mem_ready first high in access cycle R (the first strobe cycle counts as cycle 0), the strobes stay high for max(W,R)+1 cycles when no error occurs.
- R5: fifo_dir = 1 selects a memory write and fifo_dir = 0 a memory read. While the strobes are high, bus_rnw = ~fifo_dir. bus_addr and bus_wdata carry the values captured with the request.
- R6: For a read, fifo_rdata holds the bus_rdata value from the completing cycle, and is valid in the cycle where fifo_ack is high.
- R7: A bus_err or addr_err during a strobe cycle ends the access. The next cycle has strobes and bus_req low and fifo_ack low, with fault_flag = 1. fault_kind bit 0 records a bus error and bit 1 an address error.
- R8: While fault_flag is 1, fifo_req does not raise bus_req. A fault_clr pulse drops fault_flag and fault_kind on the next cycle, and requests are accepted again after that.
- R9: Each completed transfer produces exactly one fifo_ack pulse, one cycle long, in the cycle after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_req | input | 1 | Transfer request from the FIFO |
| fifo_dir | input | 1 | 1 = memory write, 0 = memory read |
| fifo_addr | input | AW | Programmed memory address |
| fifo_wdata | input | DW | Word to write |
| wait_cfg | input | WAIT_W | Minimum wait-state count |
| fifo_ack | output | 1 | One-cycle transfer-done pulse to the FIFO |
| fifo_rdata | output | DW | Word returned by a read |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership grant |
| addr_strobe | output | 1 | Address valid strobe |
| data_strobe | output | 1 | Data phase strobe |
| bus_rnw | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data |
| mem_ready | input | 1 | Memory ready to complete |
| bus_err | input | 1 | Bus error from the system |
| addr_err | input | 1 | Address error from the system |
| fault_flag | output | 1 | Sticky system-fault flag |
| fault_kind | output | 2 | Fault type bits: bit0 bus error, bit1 address error |
| fault_clr | input | 1 | Clears the fault flag |

## Verification
The bench sweeps every pairing of wait setting and ready delay in a small range, in both directions and with several grant delays. A design that ignored the minimum, or ended the access early on an early ready, would drop its strobes one cycle too soon. Error injections at the first and at a later access cycle, of each type and of both together, show up two kinds of faulty design: one that keeps the bus, and one that acknowledges an aborted transfer. The bench then holds a request while a fault is pending, which exposes a design that starts a new tenure without waiting for the clear.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACC  = 2'd2,
    ST_REL  = 2'd3
  } dma_state_e;

  localparam int FAULT_W = 2;
  localparam int FK_BUS  = 0;
  localparam int FK_ADDR = 1;
endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_req,
  input  logic       fault_flag,
  input  logic       bus_grant,
  input  logic       wait_done,
  input  logic       mem_ready,
  input  logic       any_err,
  output dma_state_e state,
  output logic       accept,
  output logic       grant_win,
  output logic       end_ok,
  output logic       end_err
);
  dma_state_e state_q, state_d;

  always_comb begin
    accept    = (state_q == ST_IDLE) && fifo_req && !fault_flag;
    grant_win = (state_q == ST_REQ) && bus_grant;
    end_err   = (state_q == ST_ACC) && any_err;
    end_ok    = (state_q == ST_ACC) && !any_err && wait_done && mem_ready;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_REQ;
      ST_REQ:  if (grant_win) state_d = ST_ACC;
      ST_ACC:  if (end_err || end_ok) state_d = ST_REL;
      ST_REL:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/dma_wait_timer.sv
module dma_wait_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] cfg,
  input  logic              run,
  output logic              done
);
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;
  logic              nonzero;

  always_comb begin
    nonzero = (cnt_q != '0);
    cnt_en  = load || (run && nonzero);
    cnt_d   = load ? cfg : (cnt_q - {{(WAIT_W-1){1'b0}}, 1'b1});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = !nonzero;
endmodule

// File: rtl/dma_fault_latch.sv
module dma_fault_latch
  import dma_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set,
  input  logic [FAULT_W-1:0] kind_in,
  input  logic               clr,
  output logic               flag,
  output logic [FAULT_W-1:0] kind
);
  logic               flag_q, flag_d;
  logic [FAULT_W-1:0] kind_q, kind_d;
  logic               upd;

  always_comb begin
    upd    = set || clr;
    flag_d = set;
    kind_d = set ? kind_in : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      kind_q <= '0;
    end else if (upd) begin
      flag_q <= flag_d;
      kind_q <= kind_d;
    end
  end

  assign flag = flag_q;
  assign kind = kind_q;
endmodule

// File: rtl/dma_single_master.sv
module dma_single_master
  import dma_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int WAIT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_req,
  input  logic               fifo_dir,
  input  logic [AW-1:0]      fifo_addr,
  input  logic [DW-1:0]      fifo_wdata,
  input  logic [WAIT_W-1:0]  wait_cfg,
  output logic               fifo_ack,
  output logic [DW-1:0]      fifo_rdata,
  output logic               bus_req,
  input  logic               bus_grant,
  output logic               addr_strobe,
  output logic               data_strobe,
  output logic               bus_rnw,
  output logic [AW-1:0]      bus_addr,
  output logic [DW-1:0]      bus_wdata,
  input  logic [DW-1:0]      bus_rdata,
  input  logic               mem_ready,
  input  logic               bus_err,
  input  logic               addr_err,
  output logic               fault_flag,
  output logic [FAULT_W-1:0] fault_kind,
  input  logic               fault_clr
);
  dma_state_e         state;
  logic               accept, grant_win, end_ok, end_err;
  logic               wait_done, any_err, in_acc;
  logic [FAULT_W-1:0] err_vec;

  logic              dir_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q;
  logic [WAIT_W-1:0] wait_q;
  logic [DW-1:0]     rdata_q, rdata_d;
  logic              rdata_en;
  logic              ack_q, ack_d;

  always_comb begin
    err_vec          = '0;
    err_vec[FK_BUS]  = bus_err;
    err_vec[FK_ADDR] = addr_err;
    any_err          = |err_vec;
    in_acc           = (state == ST_ACC);
  end

  dma_seq_ctrl u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_req   (fifo_req),
    .fault_flag (fault_flag),
    .bus_grant  (bus_grant),
    .wait_done  (wait_done),
    .mem_ready  (mem_ready),
    .any_err    (any_err),
    .state      (state),
    .accept     (accept),
    .grant_win  (grant_win),
    .end_ok     (end_ok),
    .end_err    (end_err)
  );

  dma_wait_timer #(.WAIT_W(WAIT_W)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (grant_win),
    .cfg   (wait_q),
    .run   (in_acc),
    .done  (wait_done)
  );

  dma_fault_latch u_fault (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (end_err),
    .kind_in (err_vec),
    .clr     (fault_clr),
    .flag    (fault_flag),
    .kind    (fault_kind)
  );

  // request capture, enabled when a request is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      wait_q  <= '0;
    end else if (accept) begin
      dir_q   <= fifo_dir;
      addr_q  <= fifo_addr;
      wdata_q <= fifo_wdata;
      wait_q  <= wait_cfg;
    end
  end

  always_comb begin
    rdata_en = end_ok && !dir_q;
    rdata_d  = bus_rdata;
    ack_d    = end_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign bus_req     = (state == ST_REQ) || in_acc;
  assign addr_strobe = in_acc;
  assign data_strobe = in_acc;
  assign bus_rnw     = !dir_q;
  assign bus_addr    = addr_q;
  assign bus_wdata   = wdata_q;
  assign fifo_ack    = ack_q;
  assign fifo_rdata  = rdata_q;
endmodule

// File: rtl/dma_single_master_chk.sv
module dma_single_master_chk #(
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_grant,
  input logic              addr_strobe,
  input logic              data_strobe,
  input logic              fifo_ack,
  input logic              fault_flag,
  input logic [WAIT_W-1:0] wait_cfg
);
  logic [7:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           len_q <= '0;
    else if (!addr_strobe) len_q <= '0;
    else if (len_q != 8'hFF) len_q <= len_q + 8'd1;
  end

  // R2: request held while grant absent
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !addr_strobe && !bus_grant) |=> bus_req);

  // R3: access starts only after a grant
  p_strobe_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_strobe) |-> $past(bus_grant));

  // R3: bus released when the ack is given
  p_release_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ack |-> (!bus_req && !addr_strobe && !data_strobe));

  // R4: minimum wait honoured
  p_min_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ack |-> (len_q > {{(8-WAIT_W){1'b0}}, wait_cfg}));

  // R7: no ack on the cycle a fault appears
  p_no_ack_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> (!fifo_ack && !bus_req));

  // R8: pending fault blocks new tenures
  p_fault_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && !bus_req) |=> !bus_req);

  // R9: ack is a single-cycle pulse
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ack |=> !fifo_ack);
endmodule

bind dma_single_master dma_single_master_chk #(.WAIT_W(WAIT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_req     (bus_req),
  .bus_grant   (bus_grant),
  .addr_strobe (addr_strobe),
  .data_strobe (data_strobe),
  .fifo_ack    (fifo_ack),
  .fault_flag  (fault_flag),
  .wait_cfg    (wait_cfg)
);

// File: tb/dma_single_master_bench.sv
module dma_single_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int WW = 4;

  logic          clk, rst_n;
  logic          fifo_req, fifo_dir;
  logic [AW-1:0] fifo_addr;
  logic [DW-1:0] fifo_wdata;
  logic [WW-1:0] wait_cfg;
  logic          fifo_ack;
  logic [DW-1:0] fifo_rdata;
  logic          bus_req, bus_grant, addr_strobe, data_strobe, bus_rnw;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          mem_ready, bus_err, addr_err;
  logic          fault_flag;
  logic [1:0]    fault_kind;
  logic          fault_clr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  dma_single_master #(.AW(AW), .DW(DW), .WAIT_W(WW)) u_dma_single_master (
    .clk(clk), .rst_n(rst_n), .fifo_req(fifo_req), .fifo_dir(fifo_dir),
    .fifo_addr(fifo_addr), .fifo_wdata(fifo_wdata), .wait_cfg(wait_cfg),
    .fifo_ack(fifo_ack), .fifo_rdata(fifo_rdata), .bus_req(bus_req),
    .bus_grant(bus_grant), .addr_strobe(addr_strobe), .data_strobe(data_strobe),
    .bus_rnw(bus_rnw), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .mem_ready(mem_ready), .bus_err(bus_err),
    .addr_err(addr_err), .fault_flag(fault_flag), .fault_kind(fault_kind),
    .fault_clr(fault_clr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog R9 act=%0d exp=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%0d exp=%0d", msg, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [15:0] a, input logic [15:0] d,
                      input int w, input int r, input int g, input int ea,
                      input logic [1:0] ek);
    int  e;
    bit  errp;
    errp = (ek != 2'b00);
    e    = errp ? ea : ((w > r) ? w : r);
    @(negedge clk);
    fifo_dir = wr; fifo_addr = a; fifo_wdata = d; wait_cfg = w[WW-1:0];
    bus_rdata = a ^ 16'h5A5A; fifo_req = 1'b1; bus_grant = 1'b0; mem_ready = 1'b0;
    @(negedge clk);
    chk(bus_req && !addr_strobe, "R2 bus_req after request", {bus_req, addr_strobe}, 2);
    for (int k = 0; k < g; k++) begin
      @(negedge clk);
      chk(bus_req && !addr_strobe, "R2 waiting for grant", {bus_req, addr_strobe}, 2);
    end
    bus_grant = 1'b1;
    for (int k = 0; k <= e; k++) begin
      @(negedge clk);
      chk(addr_strobe && data_strobe && bus_req, "R4 strobe length", k, e);
      if (k == 0) begin
        chk(bus_rnw == !wr, "R5 bus_rnw", bus_rnw, !wr);
        chk(bus_addr == a, "R5 bus_addr", bus_addr, a);
        if (wr) chk(bus_wdata == d, "R5 bus_wdata", bus_wdata, d);
      end
      mem_ready = (k >= r);
      bus_err   = errp && (k == ea) && ek[0];
      addr_err  = errp && (k == ea) && ek[1];
    end
    @(negedge clk);
    bus_err = 1'b0; addr_err = 1'b0; mem_ready = 1'b0; bus_grant = 1'b0; fifo_req = 1'b0;
    chk(!addr_strobe && !data_strobe, "R4 strobes end", addr_strobe, 0);
    chk(!bus_req, "R3 bus released", bus_req, 0);
    if (errp) begin
      chk(!fifo_ack, "R7 no ack on fault", fifo_ack, 0);
      chk(fault_flag, "R7 fault flag", fault_flag, 1);
      chk(fault_kind == ek, "R7 fault kind", fault_kind, ek);
    end else begin
      chk(fifo_ack, "R9 ack pulse", fifo_ack, 1);
      if (!wr) chk(fifo_rdata == (a ^ 16'h5A5A), "R6 read data", fifo_rdata, a ^ 16'h5A5A);
    end
    @(negedge clk);
    chk(!fifo_ack, "R9 ack one cycle", fifo_ack, 0);
  endtask

  task automatic clear_fault();
    @(negedge clk);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    chk(!fault_flag && fault_kind == 2'b00, "R8 clear", {fault_flag, fault_kind}, 0);
  endtask

  initial begin
    rst_n = 1'b0; fifo_req = 1'b0; fifo_dir = 1'b0; fifo_addr = '0; fifo_wdata = '0;
    wait_cfg = '0; bus_grant = 1'b0; bus_rdata = '0; mem_ready = 1'b0;
    bus_err = 1'b0; addr_err = 1'b0; fault_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bus_req && !addr_strobe && !data_strobe && !fifo_ack && !fault_flag && fault_kind == 0,
        "R1 in reset", {bus_req, addr_strobe, fifo_ack, fault_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !addr_strobe && !fifo_ack && !fault_flag,
        "R1 after reset", {bus_req, addr_strobe, fifo_ack, fault_flag}, 0);

    for (int w = 0; w < 4; w++)
      for (int r = 0; r < 5; r++)
        for (int dir = 0; dir < 2; dir++)
          xfer(dir[0], 16'(16'h1000 + w*64 + r*8 + dir), 16'(16'hC000 + w*16 + r),
               w, r, (w + r + dir) % 3, 0, 2'b00);

    // fault injections
    for (int kind = 1; kind < 4; kind++)
      for (int ea = 0; ea < 3; ea += 2) begin
        xfer(kind[0], 16'(16'h2000 + kind*4 + ea), 16'h1234, 3, 0, 1, ea, kind[1:0]);
        // held request is ignored while the fault is pending
        @(negedge clk);
        fifo_req = 1'b1;
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          chk(!bus_req && fault_flag, "R8 blocked while faulted", bus_req, 0);
        end
        fifo_req = 1'b0;
        clear_fault();
        xfer(1'b0, 16'h3000, 16'h0, 1, 2, 0, 0, 2'b00);
      end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule